// File: doc/BRIEF.md
# Byte-Write Capture and Commit Controller

This block is the write-side control logic of a byte-writable non-volatile memory, modelled in one fast clock domain. Chip enable, write enable and output enable come in asynchronous and are oversampled. The block decides when an address is taken, when a data byte is taken, and when the loaded byte is handed to the array. The array itself is not part of the block.

A write is active only while both strobes are low and output enable is high, and either strobe may be the one that controls the write. The address is taken when the active condition begins, which is the falling edge of whichever strobe went low last. The data byte is taken when the condition ends, which is the rising edge of whichever strobe went high first. Active periods that are too short are discarded as glitches.

An accepted byte starts a load-window timer. A new active strobe holds that timer, and each further accepted byte restarts it. When the timer runs out, the block emits a one-cycle commit pulse carrying the captured address and data. It then holds a busy flag for the programming time. Writes are also shut out for a fixed period after reset.

Top module: `eeprom_wr_ctrl`

## Requirements
- R1: A write is active only while the synchronised ce_n is 0, we_n is 0 and oe_n is 1. With oe_n at 0, lowering both strobes captures nothing and produces no commit.
- R2: cap_addr takes the value addr had when the active condition began, which is the falling edge of the strobe that went low last. Later changes of addr during the same write have no effect.
- R3: cap_data takes the value din had when the active condition ended, which is the rising edge of the strobe that went high first. Either we_n or ce_n may be the controlling strobe.
- R4: An active period lasting fewer than GLITCH_CYC sampled clock cycles is discarded. One lasting GLITCH_CYC cycles or more is accepted.
- R5: After an accepted byte, commit rises exactly WINDOW_CYC+3 clock edges after the raw strobe release: two synchroniser stages, one edge-detect stage, then WINDOW_CYC cycles of window. A new write that begins within the window holds the timer, and an accepted second byte restarts it, so only the last byte is committed.
- R6: commit is high for exactly one clock cycle per load window. While commit is high, cap_addr and cap_data present the byte being committed.
- R7: busy rises in the same cycle as commit and stays high for exactly PROG_CYC clock cycles.
- R8: A write that begins while busy is high is ignored. It causes no commit, and cap_addr and cap_data keep their values.
- R9: A write that begins during the first INHIBIT_CYC cycles after reset is ignored. It causes no commit and leaves cap_addr and cap_data unchanged.
- R10: After reset, commit and busy are 0 and cap_addr and cap_data are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W | Address bus |
| din | input | DATA_W | Data-in bus |
| cap_addr | output | ADDR_W | Address of the captured byte |
| cap_data | output | DATA_W | Captured data byte |
| commit | output | 1 | One-cycle pulse: captured byte goes to the array |
| busy | output | 1 | Programming in progress |

## Verification
The bench uses ADDR_W=4, GLITCH_CYC=3, WINDOW_CYC=8, PROG_CYC=12 and INHIBIT_CYC=20. With these values every address can be written in both the WE-controlled and the CE-controlled form. The exact commit latency and busy length can be counted cycle by cycle, and the power-up inhibit ends within a few dozen cycles. The short glitch threshold lets the bench sweep pulse lengths of 1 to 5 cycles on both sides of the limit. The short window lets it land a second byte inside the first byte's window.

// File: rtl/eeprom_wr_ctrl.sv
module eeprom_wr_ctrl #(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int GLITCH_CYC  = 5,        // >= 1
  parameter int WINDOW_CYC  = 25000,    // >= 2
  parameter int PROG_CYC    = 1250000,  // >= 2
  parameter int INHIBIT_CYC = 1250000   // >= 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data,
  output logic              commit,
  output logic              busy
);
  localparam int GW = $clog2(GLITCH_CYC + 1);
  localparam int WW = $clog2(WINDOW_CYC);
  localparam int PW = $clog2(PROG_CYC);
  localparam int IW = $clog2(INHIBIT_CYC);

  logic [1:0] ce_sy, we_sy, oe_sy;
  logic act, act_q, start, fin, accept, elig, long_enough;
  logic [GW-1:0] gcnt;
  logic [ADDR_W-1:0] pend_addr;
  logic win_run;
  logic [WW-1:0] win_cnt;
  logic [PW-1:0] prog_cnt;
  logic inhibit;
  logic [IW-1:0] inh_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ce_sy <= 2'b11;
      we_sy <= 2'b11;
      oe_sy <= 2'b11;
    end else begin
      ce_sy <= {ce_sy[0], ce_n};
      we_sy <= {we_sy[0], we_n};
      oe_sy <= {oe_sy[0], oe_n};
    end

  assign act         = !ce_sy[1] && !we_sy[1] && oe_sy[1];
  assign start       = act && !act_q;
  assign fin         = !act && act_q;
  assign long_enough = (gcnt == GW'(GLITCH_CYC));
  assign accept      = fin && elig && long_enough;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act_q     <= 1'b0;
      gcnt      <= '0;
      elig      <= 1'b0;
      pend_addr <= '0;
    end else begin
      act_q <= act;
      if (!act)
        gcnt <= '0;
      else if (!long_enough)
        gcnt <= gcnt + 1'b1;
      if (start) begin
        pend_addr <= addr;
        elig      <= !inhibit && !busy;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cap_addr <= '0;
      cap_data <= '0;
    end else if (accept) begin
      cap_addr <= pend_addr;
      cap_data <= din;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      win_run  <= 1'b0;
      win_cnt  <= '0;
      commit   <= 1'b0;
      busy     <= 1'b0;
      prog_cnt <= '0;
    end else begin
      commit <= 1'b0;
      if (accept) begin
        win_run <= 1'b1;
        win_cnt <= '0;
      end else if (win_run && !act) begin
        if (win_cnt == WW'(WINDOW_CYC - 1)) begin
          win_run  <= 1'b0;
          commit   <= 1'b1;
          busy     <= 1'b1;
          prog_cnt <= '0;
        end else begin
          win_cnt <= win_cnt + 1'b1;
        end
      end
      if (busy) begin
        if (prog_cnt == PW'(PROG_CYC - 1))
          busy <= 1'b0;
        else
          prog_cnt <= prog_cnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      inhibit <= 1'b1;
      inh_cnt <= '0;
    end else if (inhibit) begin
      if (inh_cnt == IW'(INHIBIT_CYC - 1))
        inhibit <= 1'b0;
      else
        inh_cnt <= inh_cnt + 1'b1;
    end

  // R5
  commit_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !act_q);
  // R6
  commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
  // R7
  busy_with_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> commit);
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(cap_addr) && $stable(cap_data)));
  // R9
  inhibit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> (!commit && !busy));
endmodule

// File: tb/eeprom_wr_ctrl_bench.sv
`timescale 1ns/1ps
module eeprom_wr_ctrl_bench;
  localparam int AW = 4, DW = 8, G = 3, W = 8, P = 12, INH = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [AW-1:0] cap_addr;
  logic [DW-1:0] cap_data;
  logic commit, busy;

  eeprom_wr_ctrl #(.ADDR_W(AW), .DATA_W(DW), .GLITCH_CYC(G), .WINDOW_CYC(W),
                   .PROG_CYC(P), .INHIBIT_CYC(INH)) u_eeprom_wr_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .cap_addr(cap_addr), .cap_data(cap_data),
    .commit(commit), .busy(busy));

  always #2 clk = ~clk;

  int checks = 0, failures = 0;
  int cyc = 0, ncom = 0, nbusy = 0, com_cyc = 0, com_a = 0, com_d = 0, rel = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (commit) begin
      ncom++;
      com_cyc = cyc;
      com_a = cap_addr;
      com_d = cap_data;
    end
    if (busy) nbusy++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe(input bit ce_ctl, input int a, input int d, input int len, input bit oe);
    @(negedge clk); addr = AW'(a); din = DW'(d); oe_n = oe;
    @(negedge clk); if (ce_ctl) we_n = 1'b0; else ce_n = 1'b0;
    @(negedge clk); if (ce_ctl) ce_n = 1'b0; else we_n = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 3) addr = ~AW'(a);
    end
    if (ce_ctl) ce_n = 1'b1; else we_n = 1'b1;
    rel = cyc;
    repeat (3) @(negedge clk);
    din = ~DW'(d);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int c0, b0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 commit", commit, 0);
    chk("R10 busy", busy, 0);
    chk("R10 cap_addr", cap_addr, 0);
    chk("R10 cap_data", cap_data, 0);

    c0 = ncom;
    strobe(1'b0, 5, 8'hA5, 6, 1'b1);
    idle(40);
    chk("R9 no commit in inhibit", ncom - c0, 0);
    chk("R9 cap_addr kept", cap_addr, 0);
    chk("R9 cap_data kept", cap_data, 0);

    for (int a = 0; a < 16; a++) begin
      int d = (a * 37 + 11) & 255;
      c0 = ncom; b0 = nbusy;
      strobe(a[0], a, d, 6, 1'b1);
      idle(W + P + 6);
      chk("R6 one commit", ncom - c0, 1);
      chk("R5 latency", com_cyc - rel, W + 3);
      chk("R2 addr", com_a, a);
      chk("R3 data", com_d, d);
      chk("R7 busy length", nbusy - b0, P);
    end

    for (int len = 1; len <= 5; len++) begin
      c0 = ncom;
      strobe(len[0], 9, 16 * len + 1, len, 1'b1);
      idle(W + P + 6);
      chk("R4 glitch filter", ncom - c0, (len >= G) ? 1 : 0);
      if (len >= G) chk("R4 data", com_d, 16 * len + 1);
    end

    c0 = ncom;
    strobe(1'b0, 3, 8'h33, 6, 1'b0);
    idle(W + P + 6);
    chk("R1 oe low no commit", ncom - c0, 0);
    chk("R1 cap_addr kept", cap_addr, 9);

    c0 = ncom;
    strobe(1'b0, 12, 8'hC3, 6, 1'b1);
    while (ncom == c0) @(negedge clk);
    strobe(1'b1, 6, 8'h66, 4, 1'b1);
    idle(W + P + 6);
    chk("R8 no second commit", ncom - c0, 1);
    chk("R8 cap_addr kept", cap_addr, 12);
    chk("R8 cap_data kept", cap_data, 8'hC3);

    c0 = ncom;
    strobe(1'b0, 2, 8'h21, 6, 1'b1);
    idle(2);
    strobe(1'b1, 14, 8'hE7, 6, 1'b1);
    idle(W + P + 6);
    chk("R5 restart single commit", ncom - c0, 1);
    chk("R5 restart latency", com_cyc - rel, W + 3);
    chk("R5 last byte addr", com_a, 14);
    chk("R5 last byte data", com_d, 8'hE7);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule